// File: doc/BRIEF.md
# Received power report encoder

This block turns per-antenna-carrier wideband received-power measurements into 16-bit report codes. It then hands those codes, one byte at a time, to a control-word framer. Each measurement arrives as a signed number of tenths of a dBm, with feeder adjustment already applied. A saturating quantizer maps it onto a 0.1 dB code scale, and the result is written into a staging store indexed by report group.

The codes that go out on the link are held in a second, live store. This store is reloaded from staging only when a hyperframe starts whose number is a multiple of 30 (0, 30, 60, 90 or 120). Every hyperframe therefore carries a complete, consistent set of codes, however measurements are timed against the frame. The framer asks for a byte by giving the subchannel number, the byte index Y and the word index Xs. The block answers one cycle later with the low or high byte of group 4·Y+Xs, or with zero when the slot does not belong to it. Groups that are switched off at reload time report zero.

Top module: `rtwp_report_enc`

## Requirements
- R1: For an input x in tenths of a dBm with -1120 ≤ x < -500, the code is x+1121. So -1120 gives 0x0001 and -501 gives 0x026C.
- R2: Inputs below -1120 give code 0x0000. Inputs of -500 or more give 0x026D. The full signed input range is covered.
- R3: The live codes reload from staging only on a `hf_start` pulse whose `hf_num` is a multiple of 30. On any other hyperframe start, the codes sent stay unchanged.
- R4: A measurement written between reloads never alters the bytes being sent. At the next reload, the most recent measurement written for each group is the one that is taken.
- R5: A read with `rd_ns` = 50 returns bits 7:0 of group n = 4·`rd_y` + `rd_xs`. A read with `rd_ns` = 51 returns bits 15:8 of the same group. `cw_hit` is 1 in both cases.
- R6: A read with any other subchannel number, or with a group index of `NGROUP` or more, returns byte 0 with `cw_hit` = 0.
- R7: A group whose `grp_enable` bit is 0 at a reload reports code 0 until a later reload finds the bit set.
- R8: After reset, every live code is 0 and `cw_byte`/`cw_hit` are 0.
- R9: `cw_byte` and `cw_hit` are registered. They answer a read request on the clock edge after the one that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | A measurement is present this cycle |
| meas_group | input | GRP_W | Report group the measurement belongs to |
| meas_tenths | input | MEAS_W | Signed power in tenths of a dBm |
| grp_enable | input | NGROUP | One bit per group: 1 = configured for reporting |
| hf_start | input | 1 | Pulse at the first cycle of a hyperframe |
| hf_num | input | HFN_W | Number of the hyperframe that starts |
| rd_valid | input | 1 | Framer requests a control-word byte |
| rd_ns | input | 6 | Subchannel number of the request |
| rd_y | input | Y_W | Byte index Y within the control word |
| rd_xs | input | 2 | Control-word index Xs within the subchannel |
| cw_byte | output | 8 | Byte to place in the control word |
| cw_hit | output | 1 | The requested slot belongs to this block |

## Verification
The quantizer is driven with a table of values. It covers deep negatives, both edges of the saturation points (-1121/-1120 and -501/-500), interior points and the extremes of the signed input. This separates an off-by-one in the bias from a wrong comparison at either edge. Hyperframe numbers are swept so that refreshing ones (0, 30, 120) and non-refreshing ones (1, 45) are mixed, which exposes a wrong stride or a reload on every frame. Measurements written between reloads, together with two writes to one group before a reload, separate a single-buffered store from a double-buffered one. Reads of distinct groups at different Y and Xs, plus reads of neighbouring subchannels, show a swapped index, a swapped byte or a slot decode that is too wide.

// File: rtl/rtwp_pkg.sv
`timescale 1ns/1ps
package rtwp_pkg;
  localparam int CODE_W       = 16;
  localparam int FLOOR_TENTHS = -1120;
  localparam int CEIL_TENTHS  = -500;
  localparam int CODE_BIAS    = 1121;
  localparam int CODE_TOP     = 621;

  typedef logic [CODE_W-1:0] code_t;

  // saturating 0.1 dB quantizer
  function automatic code_t quantize(input int x);
    if (x < FLOOR_TENTHS)
      return '0;
    else if (x >= CEIL_TENTHS)
      return code_t'(CODE_TOP);
    else
      return code_t'(x + CODE_BIAS);
  endfunction
endpackage

// File: rtl/rtwp_quant.sv
`timescale 1ns/1ps
module rtwp_quant
  import rtwp_pkg::*;
#(
  parameter int MEAS_W = 16,
  parameter int GRP_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [GRP_W-1:0]         in_group,
  input  logic signed [MEAS_W-1:0] in_tenths,
  output logic                     out_valid,
  output logic [GRP_W-1:0]         out_group,
  output code_t                    out_code
);
  int x_ext;
  assign x_ext = int'(in_tenths);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_group <= '0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_group <= in_group;
        out_code  <= quantize(x_ext);
      end
    end
  end

  // R2
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && x_ext >= CEIL_TENTHS) |=> (out_code == code_t'(CODE_TOP)));
  // R2
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && x_ext < FLOOR_TENTHS) |=> (out_code == '0));
  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_code <= code_t'(CODE_TOP)));
endmodule

// File: rtl/rtwp_bank.sv
`timescale 1ns/1ps
module rtwp_bank
  import rtwp_pkg::*;
#(
  parameter int NGROUP         = 16,
  parameter int GRP_W          = 4,
  parameter int HFN_W          = 8,
  parameter int REFRESH_STRIDE = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [GRP_W-1:0]  wr_group,
  input  code_t             wr_code,
  input  logic [NGROUP-1:0] grp_enable,
  input  logic              hf_start,
  input  logic [HFN_W-1:0]  hf_num,
  output code_t [NGROUP-1:0] live_codes
);
  logic reload;
  always_comb begin
    reload = hf_start && ((int'(hf_num) % REFRESH_STRIDE) == 0);
  end

  code_t stg [NGROUP];

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    // staging side: takes every new code
    always_ff @(posedge clk) begin
      if (rst)
        stg[g] <= '0;
      else if (wr_valid && wr_group == GRP_W'(g))
        stg[g] <= wr_code;
    end

    // live side: changes only on a reload hyperframe
    always_ff @(posedge clk) begin
      if (rst)
        live_codes[g] <= '0;
      else if (reload)
        live_codes[g] <= grp_enable[g] ? stg[g] : '0;
    end

    // R7
    unconf_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (reload && !grp_enable[g]) |=> (live_codes[g] == '0));
  end

  // R3
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reload |=> $stable(live_codes));
  // R4
  no_tear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !reload) |=> $stable(live_codes));
endmodule

// File: rtl/rtwp_slot_mux.sv
`timescale 1ns/1ps
module rtwp_slot_mux
  import rtwp_pkg::*;
#(
  parameter int NGROUP = 16,
  parameter int Y_W    = 2,
  parameter int SUB_LO = 50,
  parameter int SUB_HI = 51
) (
  input  logic               clk,
  input  logic               rst,
  input  code_t [NGROUP-1:0] live_codes,
  input  logic               rd_valid,
  input  logic [5:0]         rd_ns,
  input  logic [Y_W-1:0]     rd_y,
  input  logic [1:0]         rd_xs,
  output logic [7:0]         cw_byte,
  output logic               cw_hit
);
  localparam int IDX_W = Y_W + 2;

  logic [IDX_W-1:0] idx;
  code_t            sel;
  logic             in_rng;
  logic             is_lo, is_hi;

  always_comb begin
    idx    = {rd_y, rd_xs};
    sel    = '0;
    in_rng = 1'b0;
    for (int g = 0; g < NGROUP; g++) begin
      if (idx == IDX_W'(g)) begin
        sel    = live_codes[g];
        in_rng = 1'b1;
      end
    end
    is_lo = (rd_ns == 6'(SUB_LO));
    is_hi = (rd_ns == 6'(SUB_HI));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cw_byte <= '0;
      cw_hit  <= 1'b0;
    end else if (rd_valid && in_rng && (is_lo || is_hi)) begin
      cw_byte <= is_lo ? sel[7:0] : sel[15:8];
      cw_hit  <= 1'b1;
    end else begin
      cw_byte <= '0;
      cw_hit  <= 1'b0;
    end
  end

  // R6
  foreign_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !is_lo && !is_hi) |=> (cw_byte == '0 && !cw_hit));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !cw_hit);
endmodule

// File: rtl/rtwp_report_enc.sv
`timescale 1ns/1ps
module rtwp_report_enc
  import rtwp_pkg::*;
#(
  parameter int NGROUP         = 16,
  parameter int Y_SLOTS        = 4,
  parameter int MEAS_W         = 16,
  parameter int HFN_W          = 8,
  parameter int REFRESH_STRIDE = 30,
  parameter int SUB_LO         = 50,
  parameter int SUB_HI         = 51,
  localparam int GRP_W = (NGROUP > 1) ? $clog2(NGROUP) : 1,
  localparam int Y_W   = (Y_SLOTS > 1) ? $clog2(Y_SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     meas_valid,
  input  logic [GRP_W-1:0]         meas_group,
  input  logic signed [MEAS_W-1:0] meas_tenths,
  input  logic [NGROUP-1:0]        grp_enable,
  input  logic                     hf_start,
  input  logic [HFN_W-1:0]         hf_num,
  input  logic                     rd_valid,
  input  logic [5:0]               rd_ns,
  input  logic [Y_W-1:0]           rd_y,
  input  logic [1:0]               rd_xs,
  output logic [7:0]               cw_byte,
  output logic                     cw_hit
);
  logic               q_valid;
  logic [GRP_W-1:0]   q_group;
  code_t              q_code;
  code_t [NGROUP-1:0] live_codes;

  rtwp_quant #(.MEAS_W(MEAS_W), .GRP_W(GRP_W)) u_quant (
    .clk(clk), .rst(rst),
    .in_valid(meas_valid), .in_group(meas_group), .in_tenths(meas_tenths),
    .out_valid(q_valid), .out_group(q_group), .out_code(q_code)
  );

  rtwp_bank #(.NGROUP(NGROUP), .GRP_W(GRP_W), .HFN_W(HFN_W),
              .REFRESH_STRIDE(REFRESH_STRIDE)) u_bank (
    .clk(clk), .rst(rst),
    .wr_valid(q_valid), .wr_group(q_group), .wr_code(q_code),
    .grp_enable(grp_enable), .hf_start(hf_start), .hf_num(hf_num),
    .live_codes(live_codes)
  );

  rtwp_slot_mux #(.NGROUP(NGROUP), .Y_W(Y_W), .SUB_LO(SUB_LO),
                  .SUB_HI(SUB_HI)) u_mux (
    .clk(clk), .rst(rst), .live_codes(live_codes),
    .rd_valid(rd_valid), .rd_ns(rd_ns), .rd_y(rd_y), .rd_xs(rd_xs),
    .cw_byte(cw_byte), .cw_hit(cw_hit)
  );

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cw_byte == '0 && !cw_hit));
endmodule

// File: tb/tb_rtwp_report_enc.sv
`timescale 1ns/1ps
module tb_rtwp_report_enc;
  localparam int NV = 14;
  localparam int VIN  [NV] = '{-2000, -1121, -1120, -1119, -1000, -800, -501,
                               -500, -499, 0, 32767, -32768, -1050, -700};
  localparam int VEXP [NV] = '{0, 0, 1, 2, 121, 321, 620,
                               621, 621, 621, 621, 0, 71, 421};

  logic        clk = 0;
  logic        rst = 1;
  logic        meas_valid = 0;
  logic [3:0]  meas_group = '0;
  logic signed [15:0] meas_tenths = '0;
  logic [15:0] grp_enable = '1;
  logic        hf_start = 0;
  logic [7:0]  hf_num = '0;
  logic        rd_valid = 0;
  logic [5:0]  rd_ns = '0;
  logic [1:0]  rd_y = '0;
  logic [1:0]  rd_xs = '0;
  logic [7:0]  cw_byte;
  logic        cw_hit;

  int checks = 0;
  int errors = 0;

  rtwp_report_enc dut (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_group(meas_group),
    .meas_tenths(meas_tenths), .grp_enable(grp_enable), .hf_start(hf_start),
    .hf_num(hf_num), .rd_valid(rd_valid), .rd_ns(rd_ns), .rd_y(rd_y),
    .rd_xs(rd_xs), .cw_byte(cw_byte), .cw_hit(cw_hit)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_meas(input int grp, input int val);
    @(negedge clk);
    meas_valid  = 1;
    meas_group  = 4'(grp);
    meas_tenths = 16'(val);
    @(negedge clk);
    meas_valid  = 0;
  endtask

  task automatic frame(input int n);
    @(negedge clk);
    hf_start = 1;
    hf_num   = 8'(n);
    @(negedge clk);
    hf_start = 0;
  endtask

  task automatic rd(input int ns, input int grp, output int b, output int h);
    @(negedge clk);
    rd_valid = 1;
    rd_ns    = 6'(ns);
    rd_y     = 2'(grp / 4);
    rd_xs    = 2'(grp % 4);
    @(negedge clk);
    b = int'(cw_byte);
    h = int'(cw_hit);
    rd_valid = 0;
  endtask

  task automatic rd_code(input int grp, output int code);
    int lo, hi, h;
    rd(50, grp, lo, h);
    rd(51, grp, hi, h);
    code = hi * 256 + lo;
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c, b, h;
    repeat (3) @(negedge clk);
    // R8: outputs and live codes cleared by reset
    check("R8 out after reset", int'(cw_byte) + int'(cw_hit), 0);
    rst = 0;
    rd_code(0, c);  check("R8 group0 code", c, 0);
    rd_code(13, c); check("R8 group13 code", c, 0);

    // R1 / R2 table walk
    for (int i = 0; i < NV; i++) begin
      put_meas(i % 16, VIN[i]);
      frame(0);
      rd_code(i % 16, c);
      if (VEXP[i] == 0 || VEXP[i] == 621)
        check($sformatf("R2 x=%0d", VIN[i]), c, VEXP[i]);
      else
        check($sformatf("R1 x=%0d", VIN[i]), c, VEXP[i]);
    end

    // R5: byte split and index 4*Y+Xs (group 5 -> Y1 Xs1, group 14 -> Y3 Xs2)
    put_meas(5, -1000);   // 121 = 0x0079
    put_meas(14, -600);   // 521 = 0x0209
    frame(30);
    rd(50, 5, b, h);  check("R5 g5 low byte", b, 121);
    check("R5 g5 hit", h, 1);
    rd(51, 5, b, h);  check("R5 g5 high byte", b, 0);
    rd(50, 14, b, h); check("R5 g14 low byte", b, 9);
    rd(51, 14, b, h); check("R5 g14 high byte", b, 2);
    // R9: hit only for the cycle after a request
    @(negedge clk);
    check("R9 idle hit", int'(cw_hit), 0);

    // R6: neighbouring subchannels
    rd(49, 14, b, h); check("R6 ns49 byte", b, 0); check("R6 ns49 hit", h, 0);
    rd(52, 14, b, h); check("R6 ns52 byte", b, 0); check("R6 ns52 hit", h, 0);

    // R3: non-refresh frames keep old code
    put_meas(2, -900);    // 221
    frame(1);
    rd_code(2, c); check("R3 hfn1 no reload", c, VEXP[2]);
    frame(45);
    rd_code(2, c); check("R3 hfn45 no reload", c, VEXP[2]);
    frame(120);
    rd_code(2, c); check("R3 hfn120 reload", c, 221);

    // R4: writes between reloads do not tear; last write wins
    put_meas(2, -800);
    rd_code(2, c); check("R4 mid-frame held", c, 221);
    put_meas(2, -1100);   // 21
    frame(60);
    rd_code(2, c); check("R4 latest wins", c, 21);

    // R7: unconfigured group reports zero
    grp_enable[3] = 0;
    frame(90);
    rd_code(3, c); check("R7 disabled zero", c, 0);
    grp_enable[3] = 1;
    frame(7);
    rd_code(3, c); check("R7 still zero until reload", c, 0);
    frame(0);
    rd_code(3, c); check("R7 restored", c, VEXP[3]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule